// File: doc/BRIEF.md
# Four-Channel Converter Command Controller

This block is the host-facing control logic for a four-channel digital-to-analog converter. Each channel holds a 4-bit output range selector (span) and a 16-bit output value (code). Both are double-buffered: a pending copy that the host loads, and an active copy that drives the converter. The host reaches the block through a four-byte window. It stages a 16-bit word in two byte registers, then writes a command byte. The upper nibble of the command byte names the operation. Command bits 2:1 name the channel.

A command drops the ready flag. After a fixed, parameterized number of cycles the operation takes effect and the flag returns. The operations are: load a pending span or code; copy pending values into the active registers of one channel or of all channels; combinations of the two; and readback of either copy into the byte registers. The active registers come out on ports that stand in for the converter link.

Top module: `dac4_cmd_ctrl`

## Requirements
- R1: After reset the status byte reads 0x80 (ready), the data and command bytes read 0, and every pending and active span and code is 0.
- R2: Offsets 0 and 1 are the data low and high bytes and read back what was written. Offset 2 reads the last accepted command byte. Offset 3 reads the ready flag in bit 7, with bits 6:0 zero.
- R3: A write to offset 2 while ready is accepted. Ready reads 0 from the next cycle on. Ready returns exactly LATENCY cycles after the accepting clock edge, and the command's effect is visible in that same cycle.
- R4: Any write, to any offset, while ready is 0 is ignored.
- R5: Opcode 0x2 sets the addressed channel's pending span to data low bits 3:0. Opcode 0x3 sets its pending code to {high byte, low byte}. Active values do not change.
- R6: Opcode 0x4 copies the pending span and code of the channel given by command bits 2:1 into its active registers. Opcode 0x5 does this for all channels.
- R7: Opcodes 0x6 (span) and 0x7 (code) load the pending register of the addressed channel, then copy that channel to active in the same step.
- R8: Opcodes 0x8 (span) and 0x9 (code) load the pending register of the addressed channel, then copy every channel to active.
- R9: A command low nibble of 0xF addresses all channels for opcodes 0x2, 0x3, 0x4, 0x6, 0x7, 0x8 and 0x9.
- R10: Readback opcodes load the byte registers from the channel in bits 2:1. 0xA gives the pending span, 0xB the pending code, 0xC the active span and 0xD the active code. A span is returned as low = {0000, span}, high = 0x00.
- R11: Opcode 0xF and the undefined opcodes 0x0, 0x1 and 0xE change no register, but they still run the ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| active_span | output | 16 | Active spans, channel n at bits 4n+3:4n |
| active_code | output | 64 | Active codes, channel n at bits 16n+15:16n |

## Verification
The bench checks that pending values stay hidden from the outputs until an update, so a design that wrote through to active would show a code early. It tests the write-and-update-all forms. These must fold the freshly written channel into the global copy; a design that copied before writing would show a stale span. It issues commands and data writes during the busy window, which a design that accepted them would let overwrite state. It also measures the exact ready latency and checks that the span readback clears the high byte.

// File: rtl/dac4_pkg.sv
package dac4_pkg;
    localparam int CH_SEL_W = 2;
    localparam int NUM_CH   = 1 << CH_SEL_W;
    localparam int SPAN_W   = 4;
    localparam int CODE_W   = 16;

    typedef enum logic [3:0] {
        OP_WR_SPAN      = 4'h2,
        OP_WR_CODE      = 4'h3,
        OP_UPD          = 4'h4,
        OP_UPD_ALL      = 4'h5,
        OP_WR_SPAN_UPD  = 4'h6,
        OP_WR_CODE_UPD  = 4'h7,
        OP_WR_SPAN_UALL = 4'h8,
        OP_WR_CODE_UALL = 4'h9,
        OP_RD_P_SPAN    = 4'hA,
        OP_RD_P_CODE    = 4'hB,
        OP_RD_A_SPAN    = 4'hC,
        OP_RD_A_CODE    = 4'hD
    } op_e;

    typedef struct packed {
        logic                wr_span;
        logic                wr_code;
        logic                upd;
        logic                upd_all;
        logic                wr_all;
        logic                rd;
        logic                rd_code;
        logic                rd_active;
        logic [CH_SEL_W-1:0] ch;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(input logic [7:0] c);
        cmd_dec_t d;
        logic     every;
        d     = '0;
        every = (c[3:0] == 4'hF);
        d.ch  = c[CH_SEL_W:1];
        case (c[7:4])
            OP_WR_SPAN:      d.wr_span = 1'b1;
            OP_WR_CODE:      d.wr_code = 1'b1;
            OP_UPD:          d.upd = 1'b1;
            OP_UPD_ALL:      begin d.upd = 1'b1; d.upd_all = 1'b1; end
            OP_WR_SPAN_UPD:  begin d.wr_span = 1'b1; d.upd = 1'b1; end
            OP_WR_CODE_UPD:  begin d.wr_code = 1'b1; d.upd = 1'b1; end
            OP_WR_SPAN_UALL: begin d.wr_span = 1'b1; d.upd = 1'b1; d.upd_all = 1'b1; end
            OP_WR_CODE_UALL: begin d.wr_code = 1'b1; d.upd = 1'b1; d.upd_all = 1'b1; end
            OP_RD_P_SPAN:    d.rd = 1'b1;
            OP_RD_P_CODE:    begin d.rd = 1'b1; d.rd_code = 1'b1; end
            OP_RD_A_SPAN:    begin d.rd = 1'b1; d.rd_active = 1'b1; end
            OP_RD_A_CODE:    begin d.rd = 1'b1; d.rd_code = 1'b1; d.rd_active = 1'b1; end
            default:         d = d;
        endcase
        if (every && (d.wr_span || d.wr_code || d.upd)) begin
            d.wr_all  = 1'b1;
            d.upd_all = d.upd;
        end
        return d;
    endfunction
endpackage

// File: rtl/dac4_busy_timer.sv
module dac4_busy_timer #(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_wr,
    output logic ready,
    output logic exec
);
    localparam int CNT_W = $clog2(LATENCY + 1);

    logic [CNT_W-1:0] cnt;

    assign exec = !ready && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b1;
            cnt   <= '0;
        end else if (ready) begin
            if (cmd_wr) begin
                ready <= 1'b0;
                cnt   <= CNT_W'(LATENCY - 1);
            end
        end else if (cnt == '0) begin
            ready <= 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (ready && cmd_wr) |=> !ready); // R3
    AST_READY_RETURNS: assert property (@(posedge clk) disable iff (rst)
        exec |=> ready); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (cnt < CNT_W'(LATENCY))); // R3
endmodule

// File: rtl/dac4_chan_regs.sv
module dac4_chan_regs
    import dac4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exec,
    input  logic              wr_hit,
    input  logic              upd_hit,
    input  logic              wr_span,
    input  logic              wr_code,
    input  logic [SPAN_W-1:0] span_in,
    input  logic [CODE_W-1:0] code_in,
    output logic [SPAN_W-1:0] p_span,
    output logic [CODE_W-1:0] p_code,
    output logic [SPAN_W-1:0] a_span,
    output logic [CODE_W-1:0] a_code
);
    logic [SPAN_W-1:0] nxt_span;
    logic [CODE_W-1:0] nxt_code;

    always_comb begin
        nxt_span = (exec && wr_hit && wr_span) ? span_in : p_span;
        nxt_code = (exec && wr_hit && wr_code) ? code_in : p_code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_span <= '0;
            p_code <= '0;
            a_span <= '0;
            a_code <= '0;
        end else begin
            p_span <= nxt_span;
            p_code <= nxt_code;
            if (exec && upd_hit) begin
                a_span <= nxt_span;
                a_code <= nxt_code;
            end
        end
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(exec && upd_hit) |=> ($stable(a_span) && $stable(a_code))); // R6
    AST_PENDING_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(exec && wr_hit) |=> ($stable(p_span) && $stable(p_code))); // R5
    AST_UPDATE_MATCH: assert property (@(posedge clk) disable iff (rst)
        (exec && upd_hit) |=> (a_span == p_span && a_code == p_code)); // R7
endmodule

// File: rtl/dac4_cmd_ctrl.sv
module dac4_cmd_ctrl
    import dac4_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               bus_addr,
    input  logic                     bus_wr,
    input  logic [7:0]               bus_wdata,
    output logic [7:0]               bus_rdata,
    output logic [NUM_CH*SPAN_W-1:0] active_span,
    output logic [NUM_CH*CODE_W-1:0] active_code
);
    logic [7:0]        data_lo, data_hi, cmd_q;
    logic              ready, exec;
    cmd_dec_t          dec;
    logic [SPAN_W-1:0] p_span [NUM_CH];
    logic [CODE_W-1:0] p_code [NUM_CH];
    logic [SPAN_W-1:0] a_span [NUM_CH];
    logic [CODE_W-1:0] a_code [NUM_CH];
    logic [CODE_W-1:0] rb_word;

    assign dec = decode_cmd(cmd_q);

    dac4_busy_timer #(.LATENCY(LATENCY)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .cmd_wr (bus_wr && bus_addr == 2'd2),
        .ready  (ready),
        .exec   (exec)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dac4_chan_regs u_ch (
            .clk     (clk),
            .rst     (rst),
            .exec    (exec),
            .wr_hit  ((dec.wr_span || dec.wr_code) && (dec.wr_all || dec.ch == CH_SEL_W'(i))),
            .upd_hit (dec.upd && (dec.upd_all || dec.ch == CH_SEL_W'(i))),
            .wr_span (dec.wr_span),
            .wr_code (dec.wr_code),
            .span_in (data_lo[SPAN_W-1:0]),
            .code_in ({data_hi, data_lo}),
            .p_span  (p_span[i]),
            .p_code  (p_code[i]),
            .a_span  (a_span[i]),
            .a_code  (a_code[i])
        );
        assign active_span[i*SPAN_W +: SPAN_W] = a_span[i];
        assign active_code[i*CODE_W +: CODE_W] = a_code[i];
    end

    always_comb begin
        if (dec.rd_code)
            rb_word = dec.rd_active ? a_code[dec.ch] : p_code[dec.ch];
        else
            rb_word = CODE_W'(dec.rd_active ? a_span[dec.ch] : p_span[dec.ch]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_lo <= '0;
            data_hi <= '0;
            cmd_q   <= '0;
        end else if (exec && dec.rd) begin
            data_lo <= rb_word[7:0];
            data_hi <= rb_word[15:8];
        end else if (ready && bus_wr) begin
            case (bus_addr)
                2'd0:    data_lo <= bus_wdata;
                2'd1:    data_hi <= bus_wdata;
                2'd2:    cmd_q   <= bus_wdata;
                default: cmd_q   <= cmd_q;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            2'd0:    bus_rdata = data_lo;
            2'd1:    bus_rdata = data_hi;
            2'd2:    bus_rdata = cmd_q;
            default: bus_rdata = {ready, 7'b0};
        endcase
    end

    AST_BUSY_WRITES_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!ready && !exec) |=> ($stable(data_lo) && $stable(data_hi) && $stable(cmd_q))); // R4
    AST_SPAN_RB_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (exec && dec.rd && !dec.rd_code) |=> (data_hi == 8'h00)); // R10
    AST_NOP_NO_DATA_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (exec && !dec.rd) |=> ($stable(data_lo) && $stable(data_hi))); // R11
endmodule

// File: tb/dac4_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module dac4_cmd_ctrl_tb;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] active_span;
    logic [63:0] active_code;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        int    kind;
        int    ch;
        int    exp;
        string tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    dac4_cmd_ctrl #(.LATENCY(LAT)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .active_span(active_span), .active_code(active_code)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per cycle, samples 2 ns after the edge
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            item_t it;
            int act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = int'(bus_rdata);
                1:       act = int'(active_span[it.ch*4 +: 4]);
                default: act = int'(active_code[it.ch*16 +: 16]);
            endcase
            chk(it.tag, act, it.exp);
        end
    end

    task automatic exp_rd(input logic [1:0] a, input int exp, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it = '{0, 0, exp, tag};
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic exp_out(input int kind, input int ch, input int exp, input string tag);
        item_t it;
        @(negedge clk);
        it = '{kind, ch, exp, tag};
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic wait_ready(input bit measure);
        int n;
        bus_addr = 2'd3;
        #1;
        n = 0;
        while (!bus_rdata[7] && n < 50) begin
            @(negedge clk);
            #1;
            n++;
        end
        if (measure) chk("R3 ready latency", n, LAT);
    endtask

    task automatic cmd(input logic [7:0] c);
        wr(2'd2, c);
        bus_addr = 2'd3;
        #1;
        chk("R3 ready low after command", int'(bus_rdata[7]), 0);
        wait_ready(1);
    endtask

    task automatic set_word(input logic [15:0] w);
        wr(2'd0, w[7:0]);
        wr(2'd1, w[15:8]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        exp_rd(2'd3, 8'h80, "R1 status after reset");
        exp_rd(2'd0, 8'h00, "R1 data low after reset");
        exp_rd(2'd2, 8'h00, "R1 command after reset");
        exp_out(2, 0, 0, "R1 active code ch0");
        exp_out(1, 3, 0, "R1 active span ch3");
        // R2 byte registers
        set_word(16'h1234);
        exp_rd(2'd0, 8'h34, "R2 data low readback");
        exp_rd(2'd1, 8'h12, "R2 data high readback");
        // R5 write pending code ch1
        cmd(8'h32);
        exp_rd(2'd2, 8'h32, "R2 command readback");
        exp_out(2, 1, 0, "R5 active code untouched");
        cmd(8'hB2);
        exp_rd(2'd0, 8'h34, "R10 pending code low");
        exp_rd(2'd1, 8'h12, "R10 pending code high");
        // R5 span ch2
        set_word(16'h0005);
        cmd(8'h24);
        cmd(8'hA4);
        exp_rd(2'd0, 8'h05, "R10 pending span low");
        exp_rd(2'd1, 8'h00, "R10 span high byte zero");
        // R6 update single
        cmd(8'h42);
        exp_out(2, 1, 16'h1234, "R6 update ch1 code");
        exp_out(1, 2, 0, "R6 ch2 span not updated");
        cmd(8'h50);
        exp_out(1, 2, 5, "R6 update all ch2 span");
        // R7 write code and update ch3
        set_word(16'hBEEF);
        cmd(8'h76);
        exp_out(2, 3, 16'hBEEF, "R7 write code update ch3");
        // R8 write span ch0 and update all
        set_word(16'h5555);
        cmd(8'h34);
        set_word(16'h550A);
        cmd(8'h80);
        exp_out(1, 0, 4'hA, "R8 new span on ch0");
        exp_out(2, 2, 16'h5555, "R8 ch2 code copied");
        // R9 all-channel code write then update all
        set_word(16'h0777);
        cmd(8'h3F);
        cmd(8'h4F);
        exp_out(2, 0, 16'h0777, "R9 all ch0 code");
        exp_out(2, 3, 16'h0777, "R9 all ch3 code");
        exp_out(1, 0, 4'hA, "R9 ch0 span kept");
        // R10 active readbacks
        cmd(8'hD6);
        exp_rd(2'd0, 8'h77, "R10 active code low");
        exp_rd(2'd1, 8'h07, "R10 active code high");
        cmd(8'hC0);
        exp_rd(2'd0, 8'h0A, "R10 active span low");
        // R11 nop and undefined opcode
        set_word(16'h1111);
        cmd(8'hF0);
        exp_out(2, 0, 16'h0777, "R11 nop keeps active");
        exp_rd(2'd0, 8'h11, "R11 nop keeps data");
        cmd(8'h00);
        cmd(8'hB0);
        exp_rd(2'd0, 8'h77, "R11 pending unchanged low");
        // R4 writes while busy
        set_word(16'h2222);
        wr(2'd2, 8'h3F);
        wr(2'd2, 8'h4F);
        wr(2'd0, 8'h99);
        wait_ready(0);
        exp_rd(2'd0, 8'h22, "R4 busy data write ignored");
        exp_rd(2'd2, 8'h3F, "R4 busy command ignored");
        exp_out(2, 1, 16'h0777, "R4 no update taken");
        cmd(8'hB2);
        exp_rd(2'd1, 8'h22, "R5 code write to all applied");
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule